// File: doc/BRIEF.md
# Two-Level Virtual Address Translation Walker

This block turns a 32-bit virtual address into a 34-bit physical address for an instruction fetch, a data load or a data store. For each accepted request it works out the effective privilege and decides whether paging applies. If paging is off, the address passes through unchanged. If paging is on, the block reads up to two page table entries through a single memory port and checks the leaf entry against the access. When the leaf's accessed or dirty flag must change, it writes the new entry back with a compare-and-swap.

A walk ends with a one-cycle `done` pulse. With it come either a physical address and a read/write/execute grant set, or a fault with the page-fault cause for the access kind and the faulting virtual address. The memory port carries one request at a time. A request holds `mem_valid` until `mem_ready` is seen, and the read data is taken in that same cycle. For a compare-and-swap, the memory returns the old word in `mem_rdata` and writes `mem_wdata` only when the old word equals `mem_cmp`.

Top module: `sv32_walker`

## Requirements
- R1: The effective privilege is `mpp` when `priv` is machine (3), `mprv` is 1 and the access is a load or a store. Otherwise it is `priv`. Privilege codes: 0 user, 1 supervisor, 3 machine. Access codes: 0 fetch, 1 load, 2 store.
- R2: When `satp_mode` is 0 or the effective privilege is machine, `done` rises one cycle after acceptance with `pa` equal to the zero-extended virtual address and all three grants set. No memory request is made.
- R3: The first entry is read at `{satp_ppn, va[31:22], 2'b00}`. After a pointer entry, the second entry is read at `{ppn, va[21:12], 2'b00}`. Entry bits: V=0, R=1, W=2, X=3, U=4, A=6, D=7, PPN=[31:10].
- R4: An entry with V clear faults. An entry with V set and R, W, X all clear is a pointer. A pointer found at the second level faults.
- R5: A leaf with W set and R clear (W alone, or W with X) faults.
- R6: A leaf with U set faults when the effective privilege is not user and either `sum` is 0 or the access is a fetch. A leaf with U clear faults when the effective privilege is not supervisor.
- R7: A first-level leaf whose PPN bits [9:0] are nonzero faults. An aligned first-level leaf gives `pa = {ppn[21:10], va[21:12], va[11:0]}`.
- R8: A load needs R, or X with `mxr` set. A store needs W. A fetch needs X.
- R9: A passing leaf gets A set, and D as well for a store. If this changes the entry, it is written with compare-and-swap (`mem_cmp` = old entry). If nothing changes, no write is made.
- R10: If the compare-and-swap returns a word that differs from `mem_cmp`, the walk starts again from the root entry.
- R11: The grants are: read = R or (X and `mxr`); execute = X; write = W and (the access is a store or D is set in the final entry).
- R12: A walk fault sets `fault` with `cause` 12 for a fetch, 13 for a load and 15 for a store, and `fault_vaddr` holds the request's virtual address.
- R13: Once `mem_valid` is raised, it stays high with a stable address and write flag until `mem_ready`. `req_ready` is low while a memory request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| satp_mode | input | 1 | 1 = two-level paging, 0 = bare |
| satp_ppn | input | 22 | Root table page number |
| mprv | input | 1 | Data accesses use `mpp` privilege in machine mode |
| mpp | input | 2 | Previous privilege used when `mprv` applies |
| sum | input | 1 | Supervisor may touch user pages (data only) |
| mxr | input | 1 | Loads may read execute-only pages |
| mem_valid | output | 1 | Memory request open |
| mem_ready | input | 1 | Memory accepts request, `mem_rdata` valid |
| mem_we | output | 1 | 1 = compare-and-swap, 0 = read |
| mem_addr | output | 34 | Entry byte address |
| mem_wdata | output | 32 | New entry for compare-and-swap |
| mem_cmp | output | 32 | Expected old entry for compare-and-swap |
| mem_rdata | input | 32 | Read data / old word of compare-and-swap |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a page fault |
| cause | output | 4 | Fault cause 12, 13 or 15 |
| pa | output | 34 | Physical address |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| fault_vaddr | output | 32 | Virtual address of the last fault |

## Verification
Wrong internal state is visible at the ports within a single walk. A wrong level or base register shows up as a read from the wrong entry address, which leads to a wrong `pa`, a spurious fault, or a different number of memory reads. The bench counts memory reads for each walk and compares the count with its model. A mishandled accessed/dirty update shows up in the page memory image, which the bench compares word by word after every walk. It also shows up as a wrong write grant, and as a wrong number of compare-and-swap requests, which the bench also counts. A broken restart after a lost compare-and-swap changes the read count of that walk, so the bench catches it before the next request.

// File: rtl/sv32_walker_pkg.sv
package sv32_walker_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_A = 6;
  localparam int PTE_D = 7;

  localparam logic [3:0] CAUSE_FETCH = 4'd12;
  localparam logic [3:0] CAUSE_LOAD  = 4'd13;
  localparam logic [3:0] CAUSE_STORE = 4'd15;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CAS} walk_st_e;
endpackage

// File: rtl/sv32_pte_addr.sv
module sv32_pte_addr #(
  parameter int PPN_W = 22,
  parameter int IDX_W = 10,
  parameter int PA_W  = 34
) (
  input  logic [PPN_W-1:0]   base,
  input  logic [2*IDX_W-1:0] vpn,
  input  logic               top_lvl,
  output logic [PA_W-1:0]    addr
);
  logic [IDX_W-1:0] idx;
  always_comb begin
    idx  = top_lvl ? vpn[IDX_W +: IDX_W] : vpn[IDX_W-1:0];
    addr = {base, idx, 2'b00};
  end
endmodule

// File: rtl/sv32_pte_check.sv
module sv32_pte_check import sv32_walker_pkg::*; #(
  parameter int PTE_WD  = 32,
  parameter int IDX_W   = 10,
  parameter int PPN_LSB = 10
) (
  input  logic [PTE_WD-1:0] pte,
  input  logic              top_lvl,
  input  logic [1:0]        eff_priv,
  input  logic [1:0]        acc,
  input  logic              sum,
  input  logic              mxr,
  output logic              is_ptr,
  output logic              bad,
  output logic [PTE_WD-1:0] upd_pte
);
  logic v, r, w, x, u, priv_bad, misal, acc_bad;
  always_comb begin
    v = pte[PTE_V];
    r = pte[PTE_R];
    w = pte[PTE_W];
    x = pte[PTE_X];
    u = pte[PTE_U];
    is_ptr = v & ~(r | w | x);
    // privilege rule differs for user and supervisor leaves
    if (u) priv_bad = (eff_priv != PRIV_U) && (!sum || acc == ACC_FETCH);
    else   priv_bad = (eff_priv != PRIV_S);
    misal = top_lvl && (pte[PPN_LSB +: IDX_W] != '0);
    case (acc)
      ACC_LOAD:  acc_bad = ~(r | (x & mxr));
      ACC_STORE: acc_bad = ~w;
      default:   acc_bad = ~x;
    endcase
    bad = ~v | (is_ptr & ~top_lvl) |
          (~is_ptr & ((w & ~r) | priv_bad | misal | acc_bad));
    upd_pte = pte;
    upd_pte[PTE_A] = 1'b1;
    if (acc == ACC_STORE) upd_pte[PTE_D] = 1'b1;
  end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker import sv32_walker_pkg::*; #(
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int PPN_W   = 22,
  parameter int PTE_WD  = 32,
  parameter int PPN_LSB = 10,
  parameter int VA_W    = OFF_W + 2 * IDX_W,
  parameter int PA_W    = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        priv,
  input  logic              satp_mode,
  input  logic [PPN_W-1:0]  satp_ppn,
  input  logic              mprv,
  input  logic [1:0]        mpp,
  input  logic              sum,
  input  logic              mxr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PTE_WD-1:0] mem_wdata,
  output logic [PTE_WD-1:0] mem_cmp,
  input  logic [PTE_WD-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [3:0]        cause,
  output logic [PA_W-1:0]   pa,
  output logic              perm_r,
  output logic              perm_w,
  output logic              perm_x,
  output logic [VA_W-1:0]   fault_vaddr
);
  walk_st_e          st;
  logic              top_q, sum_q, mxr_q;
  logic [PPN_W-1:0]  base_q, root_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q, eff_q, eff_in;
  logic [PTE_WD-1:0] old_q, upd_q;
  logic [PA_W-1:0]   cas_addr_q, walk_addr;
  logic              is_ptr, bad;
  logic [PTE_WD-1:0] upd_pte, fin_pte;
  logic [PPN_W-1:0]  fin_ppn, ptr_ppn;
  logic [PA_W-1:0]   fin_pa;
  logic              fin_r, fin_w, fin_x;
  logic [3:0]        fault_code;

  sv32_pte_addr #(.PPN_W(PPN_W), .IDX_W(IDX_W), .PA_W(PA_W)) u_addr (
    .base(base_q), .vpn(va_q[VA_W-1:OFF_W]), .top_lvl(top_q), .addr(walk_addr));

  sv32_pte_check #(.PTE_WD(PTE_WD), .IDX_W(IDX_W), .PPN_LSB(PPN_LSB)) u_check (
    .pte(mem_rdata), .top_lvl(top_q), .eff_priv(eff_q), .acc(acc_q),
    .sum(sum_q), .mxr(mxr_q), .is_ptr(is_ptr), .bad(bad), .upd_pte(upd_pte));

  always_comb begin
    eff_in = (priv == PRIV_M && req_acc != ACC_FETCH && mprv) ? mpp : priv;
    req_ready = (st == ST_IDLE);
    mem_valid = (st != ST_IDLE);
    mem_we    = (st == ST_CAS);
    mem_addr  = (st == ST_CAS) ? cas_addr_q : walk_addr;
    mem_wdata = upd_q;
    mem_cmp   = old_q;
    ptr_ppn   = mem_rdata[PPN_LSB +: PPN_W];
    fin_pte   = (st == ST_CAS) ? upd_q : mem_rdata;
    fin_ppn   = fin_pte[PPN_LSB +: PPN_W];
    // superpage: low VPN bits fill the lower PPN field
    fin_pa    = top_q ? {fin_ppn[PPN_W-1:IDX_W], va_q[OFF_W +: IDX_W], va_q[OFF_W-1:0]}
                      : {fin_ppn, va_q[OFF_W-1:0]};
    fin_r     = fin_pte[PTE_R] | (fin_pte[PTE_X] & mxr_q);
    fin_x     = fin_pte[PTE_X];
    fin_w     = fin_pte[PTE_W] & ((acc_q == ACC_STORE) | fin_pte[PTE_D]);
    case (acc_q)
      ACC_FETCH: fault_code = CAUSE_FETCH;
      ACC_LOAD:  fault_code = CAUSE_LOAD;
      default:   fault_code = CAUSE_STORE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      top_q <= 1'b1;
      sum_q <= 1'b0;
      mxr_q <= 1'b0;
      base_q <= '0;
      root_q <= '0;
      va_q <= '0;
      acc_q <= ACC_FETCH;
      eff_q <= PRIV_M;
      old_q <= '0;
      upd_q <= '0;
      cas_addr_q <= '0;
      done <= 1'b0;
      fault <= 1'b0;
      cause <= '0;
      pa <= '0;
      perm_r <= 1'b0;
      perm_w <= 1'b0;
      perm_x <= 1'b0;
      fault_vaddr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          acc_q <= req_acc;
          eff_q <= eff_in;
          sum_q <= sum;
          mxr_q <= mxr;
          root_q <= satp_ppn;
          base_q <= satp_ppn;
          top_q <= 1'b1;
          if (!satp_mode || eff_in == PRIV_M) begin
            done <= 1'b1;
            fault <= 1'b0;
            pa <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
            {perm_r, perm_w, perm_x} <= 3'b111;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: if (mem_ready) begin
          if (bad) begin
            done <= 1'b1;
            fault <= 1'b1;
            cause <= fault_code;
            fault_vaddr <= va_q;
            st <= ST_IDLE;
          end else if (is_ptr) begin
            base_q <= ptr_ppn;
            top_q <= 1'b0;
          end else if (upd_pte != mem_rdata) begin
            old_q <= mem_rdata;
            upd_q <= upd_pte;
            cas_addr_q <= walk_addr;
            st <= ST_CAS;
          end else begin
            done <= 1'b1;
            fault <= 1'b0;
            pa <= fin_pa;
            {perm_r, perm_w, perm_x} <= {fin_r, fin_w, fin_x};
            st <= ST_IDLE;
          end
        end
        ST_CAS: if (mem_ready) begin
          if (mem_rdata == old_q) begin
            done <= 1'b1;
            fault <= 1'b0;
            pa <= fin_pa;
            {perm_r, perm_w, perm_x} <= {fin_r, fin_w, fin_x};
            st <= ST_IDLE;
          end else begin
            base_q <= root_q;
            top_q <= 1'b1;
            st <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        satp_mode,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [33:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_cmp,
  input logic        done,
  input logic        fault,
  input logic [3:0]  cause,
  input logic        perm_r,
  input logic        perm_w
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R13
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready); // R13
  AST_BARE_NO_WALK: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !satp_mode |=> done && !fault && !mem_valid); // R2
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> (cause == 4'd12 || cause == 4'd13 || cause == 4'd15)); // R12
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    done && !fault && perm_w |-> perm_r); // R5
  AST_CAS_SETS_ACCESSED: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_we |-> mem_wdata[6] && (mem_wdata != mem_cmp)); // R9
endmodule

bind sv32_walker sv32_walker_chk u_chk (.*);

// File: tb/sv32_walker_tb.sv
module sv32_walker_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst = 1, req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0] req_acc = 0, priv = 1, mpp = 0;
  logic satp_mode = 1, mprv = 0, sum = 0, mxr = 0;
  logic [21:0] satp_ppn = 22'd1;
  logic mem_valid, mem_we, mem_ready = 0;
  logic [33:0] mem_addr, pa;
  logic [31:0] mem_wdata, mem_cmp, mem_rdata = 0, fault_vaddr;
  logic done, fault, perm_r, perm_w, perm_x;
  logic [3:0] cause;

  sv32_walker u_dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .priv(priv), .satp_mode(satp_mode),
    .satp_ppn(satp_ppn), .mprv(mprv), .mpp(mpp), .sum(sum), .mxr(mxr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_cmp(mem_cmp), .mem_rdata(mem_rdata), .done(done),
    .fault(fault), .cause(cause), .pa(pa), .perm_r(perm_r), .perm_w(perm_w),
    .perm_x(perm_x), .fault_vaddr(fault_vaddr));

  logic [31:0] ref_mem [4096];
  logic [31:0] dut_mem [4096];
  int vec = 0, err = 0, dut_rd = 0, dut_cas = 0;
  bit race_arm = 0, race_model = 0;

  // page memory responder: one request, ready one cycle after valid
  logic [11:0] p_idx;
  logic p_we;
  logic [31:0] p_wd, p_cmp;
  always @(negedge clk) begin
    if (rst) mem_ready = 0;
    else if (mem_ready) begin
      if (p_we && dut_mem[p_idx] == p_cmp) dut_mem[p_idx] = p_wd;
      mem_ready = 0;
    end else if (mem_valid) begin
      p_idx = mem_addr[13:2]; p_we = mem_we; p_wd = mem_wdata; p_cmp = mem_cmp;
      if (mem_we) begin
        dut_cas++;
        if (race_arm) begin dut_mem[p_idx] = dut_mem[p_idx] | 32'h40; race_arm = 0; end
      end else dut_rd++;
      mem_rdata = dut_mem[p_idx];
      mem_ready = 1;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(int byte_addr, logic [31:0] v);
    ref_mem[byte_addr >> 2] = v;
    dut_mem[byte_addr >> 2] = v;
  endtask

  function automatic logic [31:0] ent(int ppn, int flags);
    return (32'(ppn) << 10) | 32'(flags);
  endfunction

  task automatic model(input logic [31:0] va, input logic [1:0] acc, output bit f,
      output logic [3:0] cs, output logic [33:0] epa, output logic [2:0] perm,
      output int rd, output int cas);
    logic [1:0] eff;
    logic [21:0] base;
    logic [31:0] pte, nw;
    logic [33:0] a;
    bit restart, r, w, x, u, bad;
    rd = 0; cas = 0; f = 0; cs = 0; epa = 0; perm = 0;
    eff = (priv == 3 && acc != 0 && mprv) ? mpp : priv;
    if (!satp_mode || eff == 3) begin epa = {2'b0, va}; perm = 3'b111; return; end
    restart = 1;
    while (restart) begin
      restart = 0;
      base = satp_ppn;
      for (int l = 1; l >= 0; l--) begin
        a = {base, (l == 1 ? va[31:22] : va[21:12]), 2'b00};
        pte = ref_mem[a[13:2]];
        rd++;
        if (!pte[0]) begin f = 1; break; end
        if (pte[3:1] == 0) begin
          if (l == 0) begin f = 1; break; end
          base = pte[31:10];
          continue;
        end
        r = pte[1]; w = pte[2]; x = pte[3]; u = pte[4];
        bad = (w && !r);
        if (u && eff != 0 && (!sum || acc == 0)) bad = 1;
        if (!u && eff != 1) bad = 1;
        if (l == 1 && pte[19:10] != 0) bad = 1;
        if (acc == 1 && !(r || (x && mxr))) bad = 1;
        if (acc == 2 && !w) bad = 1;
        if (acc == 0 && !x) bad = 1;
        if (bad) begin f = 1; break; end
        nw = pte | 32'h40 | (acc == 2 ? 32'h80 : 32'h0);
        if (nw != pte) begin
          cas++;
          if (race_model) begin
            race_model = 0;
            ref_mem[a[13:2]] = pte | 32'h40;
            restart = 1;
            break;
          end
          ref_mem[a[13:2]] = nw;
          pte = nw;
        end
        epa = (l == 1) ? {pte[31:20], va[21:12], va[11:0]} : {pte[31:10], va[11:0]};
        perm = {pte[1] | (pte[3] & mxr), pte[2] & (acc == 2 || pte[7]), pte[3]};
        break;
      end
    end
    if (f) cs = (acc == 0) ? 4'd12 : (acc == 1) ? 4'd13 : 4'd15;
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] acc, input string req);
    bit f; logic [3:0] cs; logic [33:0] epa; logic [2:0] perm; int rd, cas, n, bad_words;
    model(va, acc, f, cs, epa, perm, rd, cas);
    dut_rd = 0; dut_cas = 0;
    @(negedge clk); req_valid = 1; req_vaddr = va; req_acc = acc;
    @(negedge clk); req_valid = 0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(req, "completion seen", done, 1);
    if (rd == 0) chk(req, "identity latency", n, 0);
    chk(req, "fault", fault, f);
    if (f) begin
      chk(req, "cause", cause, cs);
      chk(req, "fault_vaddr", fault_vaddr, va);
    end else begin
      chk(req, "pa", pa, epa);
      chk(req, "perm rwx", {perm_r, perm_w, perm_x}, perm);
    end
    chk(req, "entry reads", dut_rd, rd);
    chk(req, "swap requests", dut_cas, cas);
    @(negedge clk);
    bad_words = 0;
    for (int i = 0; i < 4096; i++) if (ref_mem[i] !== dut_mem[i]) bad_words++;
    chk(req, "memory image mismatches", bad_words, 0);
  endtask

  localparam int V = 1, R = 2, W = 4, X = 8, U = 16, A = 64, D = 128;
  localparam logic [31:0] VA4K = (32'd3 << 22) | (32'd5 << 12) | 32'h123;
  localparam logic [31:0] VASP = (32'd4 << 22) | (32'd7 << 12) | 32'h456;
  localparam int ROOT_E = 32'h1000 + 3 * 4;
  localparam int LEAF_E = 32'h2000 + 5 * 4;
  localparam int SP_E   = 32'h1000 + 4 * 4;

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    err++;
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin ref_mem[i] = 0; dut_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R13", "reset req_ready", req_ready, 1);
    chk("R13", "reset done", done, 0);
    chk("R13", "reset mem_valid", mem_valid, 0);

    // R2 identity cases
    satp_mode = 0; run(VA4K, 1, "R2");
    satp_mode = 1; priv = 3; run(VA4K, 2, "R2");

    // R3 / R11 two-level walk, flags already set
    priv = 1;
    put(ROOT_E, ent(2, V));
    put(LEAF_E, ent(32'h155, R | W | V | A | D));
    run(VA4K, 1, "R3");
    // R9 accessed update on load, write grant withheld (R11)
    put(LEAF_E, ent(32'h155, R | W | V));
    run(VA4K, 1, "R9");
    run(VA4K, 2, "R9");
    // R1 machine mode with data privilege override
    priv = 3; mprv = 1; mpp = 1; run(VA4K, 1, "R1");
    put(LEAF_E, ent(32'h155, R | V | A));
    run(VA4K, 0, "R1");
    priv = 1; mprv = 0; mpp = 0;
    // R8 / R12 permission faults
    run(VA4K, 0, "R8");
    run(VA4K, 2, "R12");
    // R4 invalid entry, pointer at last level
    put(LEAF_E, 0); run(VA4K, 1, "R4");
    put(LEAF_E, ent(3, V)); run(VA4K, 1, "R4");
    // R5 reserved encodings
    put(LEAF_E, ent(32'h155, W | V | A)); run(VA4K, 2, "R5");
    put(LEAF_E, ent(32'h155, W | X | V | A)); run(VA4K, 0, "R5");
    // R6 user/supervisor rules
    put(LEAF_E, ent(32'h155, R | X | U | V | A));
    run(VA4K, 1, "R6");
    sum = 1; run(VA4K, 1, "R6");
    run(VA4K, 0, "R6");
    priv = 0; run(VA4K, 0, "R6");
    put(LEAF_E, ent(32'h155, R | V | A)); run(VA4K, 1, "R6");
    priv = 1; sum = 0;
    // R8 / R11 execute-only with and without mxr
    put(LEAF_E, ent(32'h155, X | V | A));
    run(VA4K, 1, "R8");
    mxr = 1; run(VA4K, 1, "R11"); mxr = 0;
    // R7 superpages
    put(SP_E, ent(32'h400, R | V | A)); run(VASP, 1, "R7");
    put(SP_E, ent(32'h401, R | V | A)); run(VASP, 1, "R7");
    // R10 lost swap restarts the walk
    put(LEAF_E, ent(32'h155, R | W | V));
    race_arm = 1; race_model = 1;
    run(VA4K, 1, "R10");

    summary();
    $finish;
  end
endmodule